// File: doc/BRIEF.md
# Flash Completion Status Poller

This block runs on the host side of a NOR-style flash. After software or another engine has issued a program or erase command, the poller waits for the flash's internal algorithm to finish. It reads a status byte over a simple request/acknowledge read bus, again and again, until it can decide the result. It then reports pass or fail with a one-cycle `done` pulse. If the caller asks for it, a failed operation is followed by the one-cycle reset command write, which returns the flash to array-read mode.

The poller has two ways to detect completion. In data-polling mode, bit 7 of the status byte is compared with bit 7 of the data that was written. For an erase, the comparison is with 1. In toggle mode, bit 6 is compared across successive reads, and it stops changing when the flash is idle. In both modes, bit 5 is the flash's exceeded-time flag. When it is seen, the poller does exactly one confirming read, because the completion bit can change in the same read as the flag. A read-count watchdog makes sure a flash that never answers cannot hold the poller forever.

Top module: `flash_done_poller`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `rd_req`, `wr_req`, `done`, `pass` and `fail` are all 0, and the poller is idle. This also holds when reset arrives during a run.
- R2: A `start` seen while idle latches `poll_addr`, `expect_byte`, `is_erase`, `toggle_mode` and `reset_on_fail`. On the next cycle `rd_req` rises. Every read of the run presents the latched address on `rd_addr`. A `start` during a run is ignored.
- R3: Data-polling mode (`toggle_mode`=0): a read whose bit 7 equals the expected bit 7 ends the run. On the cycle after that read's `rd_ack`, `done` and `pass` are 1.
- R4: With `is_erase`=1, the expected bit 7 is 1, whatever `expect_byte` holds.
- R5: Data-polling mode: a read with no bit-7 match and bit 5 = 1 causes exactly one more read. That read passes if bit 7 now matches and fails otherwise.
- R6: Toggle mode (`toggle_mode`=1): the first read is only a reference. Each later read passes when its bit 6 equals bit 6 of the read before it. A read whose bit 6 differs and whose bit 5 = 1 causes one more read, which passes if its bit 6 equals that read's bit 6 and fails otherwise.
- R7: On fail with `reset_on_fail`=0, `done` and `fail` are 1 on the cycle after the deciding `rd_ack`, and no write is issued. With `reset_on_fail`=1, `wr_req` rises with `wr_data`=F0h and `wr_addr` set to the poll address. It is held until `wr_ack`, and `done` and `fail` follow on the next cycle.
- R8: If neither a pass nor bit 5 = 1 occurs within `MAX_READS` reads, the read numbered `MAX_READS` fails the run. A bit 5 = 1 on that read still earns its confirming read.
- R9: `done` is a one-cycle pulse. `pass` and `fail` are each only ever 1 together with `done`, and never both.
- R10: `rd_req` stays high with a stable `rd_addr` until `rd_ack`, and `wr_req` stays high until `wr_ack`. The two requests are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a poll run (taken only when idle) |
| toggle_mode | input | 1 | 0 = data polling on bit 7, 1 = toggle detection on bit 6 |
| poll_addr | input | ADDR_W | Address to read status from |
| expect_byte | input | 8 | Byte that was programmed; bit 7 is the reference |
| is_erase | input | 1 | Erase run: expected bit 7 is 1 |
| reset_on_fail | input | 1 | Issue the F0h reset write after a fail |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_addr | output | ADDR_W | Read address |
| rd_ack | input | 1 | Read acknowledge; `rd_data` valid in this cycle |
| rd_data | input | 8 | Status byte returned by the flash |
| wr_req | output | 1 | Reset command write request |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | 8 | Write data (F0h) |
| wr_ack | input | 1 | Write acknowledge |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Run passed (with `done`) |
| fail | output | 1 | Run failed (with `done`) |

## Verification
The bench targets the recheck rule in both modes:
- A completion bit that flips on the same read as the time-limit flag must still pass. A design that failed on the flag alone would report those runs as failures.
- In toggle mode, the confirming read must be compared with the flagged read, not with an older one. A design that compared against an older read would pass a part that is still toggling.

It also targets the watchdog boundary:
- A bit 5 arriving on the last allowed read must still be confirmed. An off-by-one counter would either fail that run early or take a read too many.
- A start pulse in the middle of a run must not redirect the reads. A design that relatched its inputs would move `rd_addr`.

For erase runs, the expected byte is deliberately made to disagree with the erase rule. A design that ignored `is_erase` would pass on the first read.

// File: rtl/fdp_pkg.sv
// Shared types and constants of the flash completion status poller.
// Assumes 8-bit status bytes with the completion, toggle and limit flags
// at the fixed bit positions given below.
package fdp_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} fdp_state_e;
    typedef enum logic [1:0] {PH_FIRST, PH_NORMAL, PH_CONFIRM} fdp_phase_e;
    typedef enum logic [1:0] {VD_NEXT, VD_CONFIRM, VD_PASS, VD_FAIL} fdp_verdict_e;

    localparam int unsigned POLL_BIT   = 7;
    localparam int unsigned TOGGLE_BIT = 6;
    localparam int unsigned LIMIT_BIT  = 5;
    localparam logic [7:0]  RESET_CMD  = 8'hF0;
endpackage

// File: rtl/fdp_eval.sv
// Judges one status read. Purely combinational.
// Assumes the caller passes the flag bits of the current read, the expected
// completion bit, the toggle bit of the previous read and the watchdog's
// last-read indication.
module fdp_eval
    import fdp_pkg::*;
(
    input  logic         toggle_mode,
    input  fdp_phase_e   phase,
    input  logic         cur_poll,
    input  logic         cur_toggle,
    input  logic         cur_limit,
    input  logic         exp_poll,
    input  logic         prev_toggle,
    input  logic         wd_last,
    output fdp_verdict_e verdict
);
    logic settled;

    // Completion test of the selected mode.
    always_comb begin
        if (toggle_mode) settled = (cur_toggle == prev_toggle);
        else             settled = (cur_poll == exp_poll);
    end

    // Decide pass, fail, confirm or keep polling.
    always_comb begin
        if (phase == PH_CONFIRM)
            verdict = settled ? VD_PASS : VD_FAIL;
        else if (phase == PH_FIRST)
            verdict = wd_last ? VD_FAIL : VD_NEXT;
        else if (settled)
            verdict = VD_PASS;
        else if (cur_limit)
            verdict = VD_CONFIRM;
        else if (wd_last)
            verdict = VD_FAIL;
        else
            verdict = VD_NEXT;
    end
endmodule

// File: rtl/fdp_wdog.sv
// Counts the reads of one run and flags the read that uses up the budget.
// Assumes MAX_READS >= 1. The count is cleared when a run is accepted.
module fdp_wdog #(
    parameter int MAX_READS = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic last
);
    localparam int CNT_W = $clog2(MAX_READS + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(MAX_READS - 1);
    localparam logic [CNT_W-1:0] TOP_IDX  = CNT_W'(MAX_READS);

    logic [CNT_W-1:0] cnt;

    // Read counter, saturating at the budget.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt <= '0;
        else if (step && cnt != TOP_IDX)
            cnt <= cnt + 1'b1;
    end

    assign last = (cnt == LAST_IDX);
endmodule

// File: rtl/flash_done_poller.sv
// Host-side engine that polls a flash status byte until an embedded program
// or erase finishes. Supports data-polling and toggle modes, the one-read
// recheck after the time-limit flag, a read-count watchdog, and an optional
// F0h reset write after a fail.
// Assumes a read bus that acknowledges each request with a one-cycle rd_ack
// carrying rd_data, and a write bus that acknowledges with wr_ack.
module flash_done_poller
    import fdp_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int MAX_READS = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              toggle_mode,
    input  logic [ADDR_W-1:0] poll_addr,
    input  logic [7:0]        expect_byte,
    input  logic              is_erase,
    input  logic              reset_on_fail,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [7:0]        rd_data,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    input  logic              wr_ack,
    output logic              done,
    output logic              pass,
    output logic              fail
);
    fdp_state_e        state;
    fdp_phase_e        phase_q;
    fdp_verdict_e      verdict;
    logic [ADDR_W-1:0] addr_q;
    logic              exp_q;
    logic              mode_q;
    logic              rof_q;
    logic              prev_q;
    logic              wd_last;
    logic              accept;
    logic              rd_done;
    logic              unused_bits;

    assign accept      = (state == ST_IDLE) && start;
    assign rd_done     = (state == ST_READ) && rd_ack;
    assign unused_bits = ^{rd_data[4:0], expect_byte[6:0]};

    fdp_wdog #(.MAX_READS(MAX_READS)) u_wdog (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .step  (rd_done),
        .last  (wd_last)
    );

    fdp_eval u_eval (
        .toggle_mode (mode_q),
        .phase       (phase_q),
        .cur_poll    (rd_data[POLL_BIT]),
        .cur_toggle  (rd_data[TOGGLE_BIT]),
        .cur_limit   (rd_data[LIMIT_BIT]),
        .exp_poll    (exp_q),
        .prev_toggle (prev_q),
        .wd_last     (wd_last),
        .verdict     (verdict)
    );

    // Run sequencer: latch the request, issue reads, act on each verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            phase_q <= PH_NORMAL;
            addr_q  <= '0;
            exp_q   <= 1'b0;
            mode_q  <= 1'b0;
            rof_q   <= 1'b0;
            prev_q  <= 1'b0;
            rd_req  <= 1'b0;
            wr_req  <= 1'b0;
            done    <= 1'b0;
            pass    <= 1'b0;
            fail    <= 1'b0;
        end else begin
            done <= 1'b0;
            pass <= 1'b0;
            fail <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        addr_q  <= poll_addr;
                        exp_q   <= is_erase | expect_byte[POLL_BIT];
                        mode_q  <= toggle_mode;
                        rof_q   <= reset_on_fail;
                        phase_q <= toggle_mode ? PH_FIRST : PH_NORMAL;
                        rd_req  <= 1'b1;
                        state   <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (rd_ack) begin
                        prev_q <= rd_data[TOGGLE_BIT];
                        case (verdict)
                            VD_NEXT:    phase_q <= PH_NORMAL;
                            VD_CONFIRM: phase_q <= PH_CONFIRM;
                            VD_PASS: begin
                                rd_req <= 1'b0;
                                state  <= ST_IDLE;
                                done   <= 1'b1;
                                pass   <= 1'b1;
                            end
                            default: begin
                                rd_req <= 1'b0;
                                if (rof_q) begin
                                    wr_req <= 1'b1;
                                    state  <= ST_WRITE;
                                end else begin
                                    state <= ST_IDLE;
                                    done  <= 1'b1;
                                    fail  <= 1'b1;
                                end
                            end
                        endcase
                    end
                end
                default: begin
                    if (wr_ack) begin
                        wr_req <= 1'b0;
                        state  <= ST_IDLE;
                        done   <= 1'b1;
                        fail   <= 1'b1;
                    end
                end
            endcase
        end
    end

    assign rd_addr = addr_q;
    assign wr_addr = addr_q;
    assign wr_data = RESET_CMD;
endmodule

// File: rtl/fdp_checks.sv
// Protocol and result checks for flash_done_poller, attached by bind.
// Assumes it sees the top module's ports only.
module fdp_checks #(
    parameter int ADDR_W    = 19,
    parameter int MAX_READS = 4096
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_ack,
    input logic              wr_req,
    input logic              wr_ack,
    input logic              done,
    input logic              pass,
    input logic              fail
);
    localparam int RC_W = $clog2(MAX_READS + 3);
    logic [RC_W-1:0] reads_seen;

    // Reads acknowledged since the last end of run.
    always_ff @(posedge clk) begin
        if (!rst_n || done)
            reads_seen <= '0;
        else if (rd_req && rd_ack && reads_seen != {RC_W{1'b1}})
            reads_seen <= reads_seen + 1'b1;
    end

    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!rd_req && !wr_req && !done));

    assert_done_after_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(rd_req && rd_ack) || $past(wr_req && wr_ack)));

    assert_write_then_fail_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_ack) |=> (done && fail && !wr_req));

    assert_read_budget_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reads_seen <= RC_W'(MAX_READS + 1));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_verdict_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pass || fail) |-> (done && !(pass && fail)));

    assert_read_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

    assert_write_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> wr_req);

    assert_single_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req));
endmodule

bind flash_done_poller fdp_checks #(.ADDR_W(ADDR_W), .MAX_READS(MAX_READS)) u_fdp_checks (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_req  (rd_req),
    .rd_addr (rd_addr),
    .rd_ack  (rd_ack),
    .wr_req  (wr_req),
    .wr_ack  (wr_ack),
    .done    (done),
    .pass    (pass),
    .fail    (fail)
);

// File: tb/sim_flash_done_poller.sv
// Directed bench for flash_done_poller: one task per scenario.
module sim_flash_done_poller;
    localparam int AW   = 19;
    localparam int MAXR = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          toggle_mode = 1'b0;
    logic [AW-1:0] poll_addr = '0;
    logic [7:0]    expect_byte = 8'h00;
    logic          is_erase = 1'b0;
    logic          reset_on_fail = 1'b0;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          rd_ack = 1'b0;
    logic [7:0]    rd_data = 8'h00;
    logic          wr_req;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic          wr_ack = 1'b0;
    logic          done;
    logic          pass;
    logic          fail;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] resp [0:15];

    always #10 clk = ~clk;

    flash_done_poller #(.ADDR_W(AW), .MAX_READS(MAXR)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .toggle_mode(toggle_mode),
        .poll_addr(poll_addr), .expect_byte(expect_byte), .is_erase(is_erase),
        .reset_on_fail(reset_on_fail), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_ack(rd_ack), .rd_data(rd_data), .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_ack(wr_ack), .done(done), .pass(pass), .fail(fail)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Serves reads from resp[] (the last entry repeats), then checks the outcome.
    task automatic run_case(input string req, input logic tm, input logic [7:0] exb,
                            input logic er, input logic rof, input logic [AW-1:0] addr,
                            input int nresp, input logic exp_pass, input int exp_reads,
                            input logic exp_wr, input logic inject);
        int reads = 0;
        int wrs = 0;
        int cyc = 0;
        bit finished = 0;
        bit addr_ok = 1;
        bit injected = 0;
        logic got_pass = 0;
        logic got_fail = 0;
        logic [AW-1:0] wa = '0;
        logic [7:0] wd = '0;
        @(negedge clk);
        start = 1; toggle_mode = tm; expect_byte = exb; is_erase = er;
        reset_on_fail = rof; poll_addr = addr;
        @(negedge clk);
        start = 0;
        while (!finished && cyc < 500) begin
            rd_ack = 0; wr_ack = 0; start = 0;
            if (done) begin
                finished = 1; got_pass = pass; got_fail = fail;
            end else if (rd_req) begin
                rd_ack = 1;
                rd_data = resp[(reads < nresp) ? reads : nresp - 1];
                if (rd_addr != addr) addr_ok = 0;
                reads++;
            end else if (wr_req) begin
                wr_ack = 1; wa = wr_addr; wd = wr_data; wrs++;
            end
            if (inject && !injected && reads == 1 && !finished) begin
                start = 1; poll_addr = ~addr; expect_byte = ~exb; toggle_mode = ~tm;
                injected = 1;
            end
            @(negedge clk);
            cyc++;
        end
        rd_ack = 0; wr_ack = 0; start = 0;
        check(finished, req, "run finished", finished, 1);
        check(got_pass == exp_pass && got_fail == !exp_pass, req, "pass/fail",
              {got_pass, got_fail}, {exp_pass, !exp_pass});
        check(reads == exp_reads, req, "read count", reads, exp_reads);
        check(addr_ok, "R2", "read address held", addr_ok, 1);
        check(wrs == (exp_wr ? 1 : 0), "R7", "reset write count", wrs, exp_wr ? 1 : 0);
        if (exp_wr) begin
            check(wd == 8'hF0, "R7", "reset write data", wd, 8'hF0);
            check(wa == addr, "R7", "reset write address", wa, addr);
        end
        check(!done && !pass && !fail, "R9", "done is one cycle", {done, pass, fail}, 0);
    endtask

    task automatic t_reset_state();
        repeat (3) @(negedge clk);
        check(!rd_req && !wr_req && !done && !pass && !fail, "R1", "outputs in reset",
              {rd_req, wr_req, done, pass, fail}, 0);
        rst_n = 1;
        @(negedge clk);
        check(!rd_req && !wr_req && !done, "R1", "idle after reset",
              {rd_req, wr_req, done}, 0);
    endtask

    task automatic t_reset_midrun();
        @(negedge clk);
        start = 1; toggle_mode = 1; poll_addr = 19'h00777; reset_on_fail = 1;
        @(negedge clk);
        start = 0;
        check(rd_req, "R2", "read requested after start", rd_req, 1);
        rst_n = 0;
        @(negedge clk);
        check(!rd_req && !wr_req && !done, "R1", "reset mid run",
              {rd_req, wr_req, done}, 0);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic t_data_pass_with_restart();
        resp[0] = 8'h05; resp[1] = 8'h05; resp[2] = 8'hA5;
        run_case("R3", 0, 8'hA5, 0, 0, 19'h12345, 3, 1, 3, 0, 1);
    endtask

    task automatic t_erase_pass();
        resp[0] = 8'h00; resp[1] = 8'h1F; resp[2] = 8'h80;
        run_case("R4", 0, 8'h00, 1, 0, 19'h40010, 3, 1, 3, 0, 0);
    endtask

    task automatic t_data_limit_recover();
        resp[0] = 8'h20; resp[1] = 8'h80;
        run_case("R5", 0, 8'h80, 0, 0, 19'h00001, 2, 1, 2, 0, 0);
    endtask

    task automatic t_data_limit_fail();
        resp[0] = 8'h20; resp[1] = 8'h20;
        run_case("R5", 0, 8'h80, 0, 0, 19'h00002, 2, 0, 2, 0, 0);
    endtask

    task automatic t_data_limit_fail_reset();
        resp[0] = 8'hA0; resp[1] = 8'hA0;
        run_case("R7", 0, 8'h01, 0, 1, 19'h5AA55, 2, 0, 2, 1, 0);
    endtask

    task automatic t_toggle_pass();
        resp[0] = 8'h40; resp[1] = 8'h00; resp[2] = 8'h40; resp[3] = 8'h40;
        run_case("R6", 1, 8'h00, 0, 0, 19'h3FFFF, 4, 1, 4, 0, 0);
    endtask

    task automatic t_toggle_limit_recover();
        resp[0] = 8'h40; resp[1] = 8'h00; resp[2] = 8'h60; resp[3] = 8'h60;
        run_case("R6", 1, 8'h00, 0, 0, 19'h20000, 4, 1, 4, 0, 0);
    endtask

    task automatic t_toggle_limit_fail();
        resp[0] = 8'h40; resp[1] = 8'h00; resp[2] = 8'h60; resp[3] = 8'h20;
        run_case("R6", 1, 8'h00, 0, 1, 19'h10101, 4, 0, 4, 1, 0);
    endtask

    task automatic t_watchdog_data();
        resp[0] = 8'h00;
        run_case("R8", 0, 8'h80, 0, 0, 19'h00100, 1, 0, MAXR, 0, 0);
    endtask

    task automatic t_watchdog_toggle();
        for (int i = 0; i < MAXR; i++) resp[i] = (i % 2 == 0) ? 8'h40 : 8'h00;
        run_case("R8", 1, 8'h00, 0, 1, 19'h00200, MAXR, 0, MAXR, 1, 0);
    endtask

    task automatic t_watchdog_limit_on_last();
        for (int i = 0; i < MAXR - 1; i++) resp[i] = 8'h00;
        resp[MAXR - 1] = 8'h20;
        resp[MAXR]     = 8'h80;
        run_case("R8", 0, 8'h80, 0, 0, 19'h00300, MAXR + 1, 1, MAXR + 1, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R10 bench watchdog expired: actual=%0d expected=%0d", 100000, 0);
        summary();
        $finish;
    end

    initial begin
        t_reset_state();
        t_reset_midrun();
        t_data_pass_with_restart();
        t_erase_pass();
        t_data_limit_recover();
        t_data_limit_fail();
        t_data_limit_fail_reset();
        t_toggle_pass();
        t_toggle_limit_recover();
        t_toggle_limit_fail();
        t_watchdog_data();
        t_watchdog_toggle();
        t_watchdog_limit_on_last();
        repeat (3) @(negedge clk);
        summary();
        $finish;
    end
endmodule